// File: doc/BRIEF.md
# Shift-Gain Proportional-Integral Timing Loop Filter

This block sits between a bit-timing error detector and a digitally controlled oscillator in a clock recovery loop. Each time the detector produces a signed timing error and strobes it as valid, the filter forms a proportional term and adds it to a running integral term. The sum leaves as a signed frequency-control word, which the oscillator uses to pull its phase toward the data transitions.

Both loop gains are powers of two. Each is given as a run-time arithmetic right-shift count, so the loop bandwidth and damping can be retuned without any multiplier. The error is left-aligned into the wide working word before either shift. The integrator adder and the output adder detect two's-complement overflow and clamp to the largest positive or negative value instead of wrapping. A control input clears the integral term and another freezes it. Clear wins when both are high.

Top module: `tloop_pi_filter`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid error, `ctrl_o` reads 0 and `ctrl_valid_o` reads 0. The integral term starts at 0.
- R2: The error `err_i` is taken as two's complement and placed in the top `ERR_W` bits of an `ACC_W`-bit working word, with zeros below. With the default widths the working value is err × 2^18.
- R3: The proportional term is the working value arithmetically shifted right by `kp_shift_i`, rounding toward minus infinity.
- R4: On each valid error, if neither clear nor freeze is active, the integral term gains the working value shifted arithmetically right by `ki_shift_i`. It changes on no other cycle, except through clear.
- R5: The clock edge that samples `err_valid_i` high loads `ctrl_o` with the proportional term plus the integral term after that sample's update. In the same edge `ctrl_valid_o` is set high. It stays high only as long as valid samples continue on consecutive cycles.
- R6: While `err_valid_i` is low, `ctrl_o` holds its last value and `ctrl_valid_o` stays low.
- R7: The integrator addition saturates at 2^(ACC_W-1)-1 and at -2^(ACC_W-1) and never wraps.
- R8: The output addition saturates at the same two limits and never wraps.
- R9: `integ_clear_i` high at a clock edge sets the integral term to 0, whether or not an error is valid. A valid error in that cycle produces an output equal to its proportional term alone.
- R10: `integ_hold_i` high with clear low keeps the integral term unchanged. Valid errors in that state still produce the proportional term plus the frozen integral term.
- R11: A new shift count takes effect from the next valid error, with no other side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| err_valid_i | input | 1 | Timing error valid strobe |
| err_i | input | ERR_W (14) | Signed timing error |
| kp_shift_i | input | SHIFT_W (5) | Proportional gain as a right-shift count |
| ki_shift_i | input | SHIFT_W (5) | Integral gain as a right-shift count |
| integ_clear_i | input | 1 | Clear the integral term (has priority over freeze) |
| integ_hold_i | input | 1 | Freeze the integral term |
| ctrl_o | output | ACC_W (32) | Signed frequency-control word |
| ctrl_valid_o | output | 1 | One-clock strobe for each new control word |

## Verification
The assertions assume that the error, the shift counts and the clear and freeze controls are stable and free of X at every edge where the internal reset is released. They also assume that the block sees no valid errors during the two synchronizer cycles after `rst_n` rises. The stimulus drives every input on the falling edge, so each input is settled well before the edge that samples it. It also waits several cycles after reset release before the first error. The sign-preservation properties for saturation rely only on non-negative errors and a non-negative integral term. The stimulus reaches these cases by driving full-scale positive and negative errors with a shift of zero.

// File: rtl/tloop_pkg.sv
package tloop_pkg;

  localparam int unsigned TLOOP_ERR_W   = 14;
  localparam int unsigned TLOOP_ACC_W   = 32;
  localparam int unsigned TLOOP_SHIFT_W = 5;

  // What the integrator does in a given cycle.
  typedef enum logic [1:0] {
    INTEG_IDLE  = 2'd0,
    INTEG_STEP  = 2'd1,
    INTEG_HOLD  = 2'd2,
    INTEG_CLEAR = 2'd3
  } integ_mode_e;

endpackage

// File: rtl/tloop_sat_add.sv
// Two's-complement adder that clamps to the extreme values on overflow.
module tloop_sat_add #(
  parameter int unsigned W = 32
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] sum_o
);

  localparam logic signed [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] raw;
  logic                same_sign;
  logic                flipped;

  always_comb begin
    raw       = a_i + b_i;
    same_sign = (a_i[W-1] == b_i[W-1]);
    flipped   = (raw[W-1] != a_i[W-1]);
    if (same_sign && flipped) begin
      sum_o = a_i[W-1] ? NEG_LIM : POS_LIM;
    end else begin
      sum_o = raw;
    end
  end

endmodule

// File: rtl/tloop_gain_shift.sv
// Power-of-two gain: arithmetic right shift by a run-time count.
module tloop_gain_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 5
) (
  input  logic signed [W-1:0]  x_i,
  input  logic        [SW-1:0] sh_i,
  output logic signed [W-1:0]  y_o
);

  always_comb begin
    y_o = x_i >>> sh_i;
  end

endmodule

// File: rtl/tloop_integrator.sv
// Saturating accumulator with clear (priority) and freeze.
module tloop_integrator
  import tloop_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en_i,
  input  logic                clear_i,
  input  logic                hold_i,
  input  logic signed [W-1:0] inc_i,
  output logic signed [W-1:0] integ_q_o,
  output logic signed [W-1:0] integ_d_o
);

  integ_mode_e         mode;
  logic signed [W-1:0] integ_q;
  logic signed [W-1:0] integ_d;
  logic signed [W-1:0] integ_sum;
  logic                integ_en;

  tloop_sat_add #(.W(W)) u_add (
    .a_i   (integ_q),
    .b_i   (inc_i),
    .sum_o (integ_sum)
  );

  always_comb begin
    if (clear_i) begin
      mode = INTEG_CLEAR;
    end else if (hold_i) begin
      mode = INTEG_HOLD;
    end else if (step_en_i) begin
      mode = INTEG_STEP;
    end else begin
      mode = INTEG_IDLE;
    end
  end

  always_comb begin
    integ_d  = integ_q;
    integ_en = 1'b0;
    unique case (mode)
      INTEG_CLEAR: begin
        integ_d  = '0;
        integ_en = 1'b1;
      end
      INTEG_STEP: begin
        integ_d  = integ_sum;
        integ_en = 1'b1;
      end
      default: begin
        integ_d  = integ_q;
        integ_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
    end else if (integ_en) begin
      integ_q <= integ_d;
    end
  end

  assign integ_q_o = integ_q;
  assign integ_d_o = integ_d;

endmodule

// File: rtl/tloop_pi_filter.sv
module tloop_pi_filter
  import tloop_pkg::*;
#(
  parameter int unsigned ERR_W   = TLOOP_ERR_W,
  parameter int unsigned ACC_W   = TLOOP_ACC_W,
  parameter int unsigned SHIFT_W = TLOOP_SHIFT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               err_valid_i,
  input  logic [ERR_W-1:0]   err_i,
  input  logic [SHIFT_W-1:0] kp_shift_i,
  input  logic [SHIFT_W-1:0] ki_shift_i,
  input  logic               integ_clear_i,
  input  logic               integ_hold_i,
  output logic [ACC_W-1:0]   ctrl_o,
  output logic               ctrl_valid_o
);

  localparam int unsigned PAD_W = ACC_W - ERR_W;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  // Error left-aligned in the working word.
  logic signed [ACC_W-1:0] err_wide;
  logic signed [ACC_W-1:0] prop_term;
  logic signed [ACC_W-1:0] integ_inc;
  logic signed [ACC_W-1:0] integ_q;
  logic signed [ACC_W-1:0] integ_d;
  logic signed [ACC_W-1:0] out_sum;

  assign err_wide = {err_i, {PAD_W{1'b0}}};

  tloop_gain_shift #(.W(ACC_W), .SW(SHIFT_W)) u_kp (
    .x_i  (err_wide),
    .sh_i (kp_shift_i),
    .y_o  (prop_term)
  );

  tloop_gain_shift #(.W(ACC_W), .SW(SHIFT_W)) u_ki (
    .x_i  (err_wide),
    .sh_i (ki_shift_i),
    .y_o  (integ_inc)
  );

  tloop_integrator #(.W(ACC_W)) u_integ (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step_en_i (err_valid_i),
    .clear_i   (integ_clear_i),
    .hold_i    (integ_hold_i),
    .inc_i     (integ_inc),
    .integ_q_o (integ_q),
    .integ_d_o (integ_d)
  );

  tloop_sat_add #(.W(ACC_W)) u_out_add (
    .a_i   (prop_term),
    .b_i   (integ_d),
    .sum_o (out_sum)
  );

  // Output register with clock enable and strobe.
  logic [ACC_W-1:0] ctrl_q;
  logic [ACC_W-1:0] ctrl_d;
  logic             cval_q;
  logic             cval_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (err_valid_i) begin
      ctrl_d = out_sum;
    end
    cval_d = err_valid_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      cval_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cval_q <= cval_d;
    end
  end

  assign ctrl_o       = ctrl_q;
  assign ctrl_valid_o = cval_q;

endmodule

// File: rtl/tloop_pi_filter_chk.sv
module tloop_pi_filter_chk #(
  parameter int unsigned ERR_W = 14,
  parameter int unsigned ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_valid_i,
  input logic [ERR_W-1:0] err_i,
  input logic             integ_clear_i,
  input logic             integ_hold_i,
  input logic [ACC_W-1:0] integ_q,
  input logic [ACC_W-1:0] ctrl_o,
  input logic             ctrl_valid_o
);

  // R5
  a_r5_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid_i |=> ctrl_valid_o);

  // R5 / R6
  a_r6_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid_i |=> !ctrl_valid_o);

  a_r6_output_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid_i |=> $stable(ctrl_o));

  // R4
  a_r4_integ_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_valid_i && !integ_clear_i) |=> $stable(integ_q));

  // R9
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    integ_clear_i |=> (integ_q == '0));

  // R10
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_hold_i && !integ_clear_i) |=> $stable(integ_q));

  // R7
  a_r7_no_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid_i && !err_i[ERR_W-1] && !integ_q[ACC_W-1]) |=> !integ_q[ACC_W-1]);

  // R8
  a_r8_no_out_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid_i && !err_i[ERR_W-1] && !integ_q[ACC_W-1]) |=> !ctrl_o[ACC_W-1]);

endmodule

bind tloop_pi_filter tloop_pi_filter_chk #(
  .ERR_W (ERR_W),
  .ACC_W (ACC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .err_valid_i   (err_valid_i),
  .err_i         (err_i),
  .integ_clear_i (integ_clear_i),
  .integ_hold_i  (integ_hold_i),
  .integ_q       (integ_q),
  .ctrl_o        (ctrl_o),
  .ctrl_valid_o  (ctrl_valid_o)
);

// File: tb/tloop_pi_filter_test.sv
`timescale 1ns/1ps
module tloop_pi_filter_test;

  localparam int ERR_W = 14;
  localparam int ACC_W = 32;
  localparam int SH_W  = 5;
  localparam longint POS_LIM = 64'sd2147483647;
  localparam longint NEG_LIM = -64'sd2147483648;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              err_valid_i;
  logic [ERR_W-1:0]  err_i;
  logic [SH_W-1:0]   kp_shift_i;
  logic [SH_W-1:0]   ki_shift_i;
  logic              integ_clear_i;
  logic              integ_hold_i;
  logic [ACC_W-1:0]  ctrl_o;
  logic              ctrl_valid_o;

  always #2.5 clk = ~clk;

  tloop_pi_filter uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_valid_i   (err_valid_i),
    .err_i         (err_i),
    .kp_shift_i    (kp_shift_i),
    .ki_shift_i    (ki_shift_i),
    .integ_clear_i (integ_clear_i),
    .integ_hold_i  (integ_hold_i),
    .ctrl_o        (ctrl_o),
    .ctrl_valid_o  (ctrl_valid_o)
  );

  int     checks = 0;
  int     fails  = 0;
  bit     done   = 0;
  longint exp_q[$];
  string  tag_q[$];
  longint m_integ = 0;
  longint last_out = 0;

  function automatic longint sat(longint v);
    if (v > POS_LIM) return POS_LIM;
    if (v < NEG_LIM) return NEG_LIM;
    return v;
  endfunction

  // Driver: model the sample, queue the expectation, strobe one cycle.
  task automatic send(int e, string tag);
    longint scaled, p, inc;
    @(negedge clk);
    scaled = longint'(e) * (64'sd1 <<< (ACC_W - ERR_W));   // R2
    p   = scaled >>> kp_shift_i;                            // R3
    inc = scaled >>> ki_shift_i;
    if (integ_clear_i)      m_integ = 0;
    else if (!integ_hold_i) m_integ = sat(m_integ + inc);   // R4 R7
    exp_q.push_back(sat(p + m_integ));                      // R8
    tag_q.push_back(tag);
    err_i       = ERR_W'(e);
    err_valid_i = 1'b1;
    @(negedge clk);
    err_valid_i = 1'b0;
  endtask

  task automatic clear_only();
    @(negedge clk);
    integ_clear_i = 1'b1;
    m_integ = 0;
    @(negedge clk);
    integ_clear_i = 1'b0;
  endtask

  task automatic idle_check(int n, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      checks++;
      if (ctrl_valid_o !== 1'b0 || longint'($signed(ctrl_o)) != last_out) begin
        fails++;
        $display("FAIL %s: idle ctrl_o=%0d valid=%b expected %0d valid=0",
                 tag, $signed(ctrl_o), ctrl_valid_o, last_out);
      end
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && ctrl_valid_o === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5: unexpected strobe ctrl_o=%0d expected no strobe", $signed(ctrl_o));
      end else begin
        longint e;
        string  t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_out = e;
        if (longint'($signed(ctrl_o)) != e) begin
          fails++;
          $display("FAIL %s: ctrl_o=%0d expected %0d", t, $signed(ctrl_o), e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5: watchdog expired, actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    err_valid_i = 1'b0;
    err_i = '0;
    kp_shift_i = 5'd4;
    ki_shift_i = 5'd10;
    integ_clear_i = 1'b0;
    integ_hold_i = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (ctrl_o !== '0 || ctrl_valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: in reset ctrl_o=%0h valid=%b expected 0/0", ctrl_o, ctrl_valid_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check(2, "R1");

    // Main function, several patterns (R2 R3 R4 R5)
    send(100,   "R2_R3_R4_R5");
    send(-250,  "R2_R3_R4_R5");
    send(8191,  "R3_R4");
    send(-8192, "R3_R4");
    send(0,     "R4_R5");
    send(1,     "R2_R5");
    idle_check(5, "R6");

    // Gain change at run time (R11)
    kp_shift_i = 5'd2;
    ki_shift_i = 5'd6;
    send(300, "R11");
    send(-77, "R11");

    // Freeze (R10)
    integ_hold_i = 1'b1;
    send(500,  "R10");
    send(-500, "R10");
    idle_check(2, "R6");
    // Clear has priority over freeze (R9 R10)
    integ_clear_i = 1'b1;
    send(40, "R9_R10");
    integ_clear_i = 1'b0;
    integ_hold_i = 1'b0;
    send(1000, "R4");
    clear_only();
    idle_check(1, "R6");
    send(-3, "R9");

    // Positive saturation
    clear_only();
    kp_shift_i = 5'd31;
    ki_shift_i = 5'd0;
    send(8191, "R7");
    send(8191, "R7");
    send(8191, "R7");
    kp_shift_i = 5'd0;
    send(8191, "R8");
    // Negative saturation
    clear_only();
    kp_shift_i = 5'd31;
    send(-8192, "R7");
    send(-8192, "R7");
    kp_shift_i = 5'd0;
    send(-8192, "R8");
    idle_check(3, "R6");

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5: %0d results missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule